// File: doc/BRIEF.md
# Ring-Wrapping Request-Driven DMA Channel

This block is one DMA channel that copies data between two memory locations in dual-address fashion. Every unit transfer first reads one item from the source address and then writes that same item to the destination address over a generic request/acknowledge memory port. Software programs the source and destination addresses, a total byte count and a control word, then sets the enable bit. After that, each accepted external request moves exactly one item of the chosen size (1, 2 or 4 bytes).

Each address has its own update mode and its own wrap width. A non-zero wrap width freezes the upper address bits and lets only the chosen number of low bits count, so the address circles inside a power-of-two window. A ring buffer can therefore be drained or filled without any software reload. Leaving the window raises a sticky wrap flag. Reaching a zero byte count sets a done flag and turns the channel off. Each flag can drive its own interrupt line.

Top module: `dmaRingChannel`

## Requirements
- R1: Each unit transfer is a read at the source address followed by a write of the read data to the destination address. `memReq` and `memWe` hold steady until `memAck` is seen, and the write data equals the data read.
- R2: With control bit 3 = 0 (level mode), transfers repeat back to back for as long as `reqN` is low and the channel is enabled.
- R3: With control bit 3 = 1 (edge mode), each falling edge of `reqN` starts one transfer. A `reqN` already low when control bit 0 (enable) is set counts as one request, and a line that stays low gives no further transfers.
- R4: In edge mode, a falling edge seen during a transfer is kept in one pending bit and served after that transfer.
- R5: While enable (control bit 0) is 0, the request line is ignored: no memory access occurs and the addresses and count stay unchanged.
- R6: The access size is control bits 5:4 (0 = byte, 1 = 2 bytes, 2 = 4 bytes). Source mode is bits 7:6 and destination mode is bits 9:8 (0 = fixed, 1 = increment, 2 = decrement). The step equals the size in bytes.
- R7: The source wrap width is control bits 14:10 and the destination wrap width is bits 19:15. A width w > 0 keeps the address bits above w-1 fixed and counts modulo 2^w. A width of 0 lets the address carry across its full width.
- R8: Any address update that leaves its wrap window sets the wrap flag (control bit 2). `wrapIrq` equals that flag ANDed with control bit 21.
- R9: Register offsets: 0 = source, 1 = destination, 2 = byte count, 3 = control. After each unit the byte count falls by the step. When it reaches zero, the done flag (control bit 1) is set, enable is cleared and the channel stops.
- R10: Writing 0 to control bit 1 or bit 2 clears that flag, and writing 1 leaves it unchanged. `doneIrq` equals the done flag ANDed with control bit 20, and `xferDone` equals the done flag.
- R11: `reqAck` is high exactly in the read phase of each transfer.
- R12: After reset, all registers read 0 and `memReq`, `reqAck`, `doneIrq`, `wrapIrq` and `xferDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| reqN | input | 1 | Active-low transfer request |
| reqAck | output | 1 | Request acknowledge, high during the read phase |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 32 | Memory byte address |
| memSize | output | 2 | Access size code |
| memWdata | output | 32 | Write data, right aligned |
| memRdata | input | 32 | Read data, right aligned |
| memAck | input | 1 | Memory access complete |
| doneIrq | output | 1 | Transfer-end interrupt |
| wrapIrq | output | 1 | Wrap-window overflow interrupt |
| xferDone | output | 1 | Transfer-end flag |

## Verification
The hardest case to reach from the ports is a request that arrives while a transfer is already under way, so that the single pending bit is the only record of it. The stimulus produces this by making a low-high-low pattern on `reqN` on consecutive cycles, so that the second falling edge lands in the read or write phase of the first transfer. A second hard case is a line that is already low when the channel is enabled. The bench sets this up by lowering `reqN` before it writes the enable bit, and then counts memory writes to confirm that exactly one transfer follows.

// File: rtl/dmaRingPkg.sv
package dmaRingPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} chanState_e;

  typedef struct packed {
    logic startUnit;
    logic latchRead;
    logic finishUnit;
  } ctrlStrobe_t;

  localparam logic [1:0] UPD_FIXED = 2'd0;
  localparam logic [1:0] UPD_INC   = 2'd1;
  localparam logic [1:0] UPD_DEC   = 2'd2;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam int CB_EN    = 0;
  localparam int CB_DONE  = 1;
  localparam int CB_WRAP  = 2;
  localparam int CB_EDGE  = 3;
  localparam int CB_SIZE  = 4;
  localparam int CB_SUPD  = 6;
  localparam int CB_DUPD  = 8;
  localparam int CB_SWRAP = 10;
  localparam int CB_DWRAP = 15;
  localparam int CB_DIE   = 20;
  localparam int CB_WIE   = 21;
  localparam int CB_USED  = 22;
endpackage

// File: rtl/dmaAddrStep.sv
module dmaAddrStep
  import dmaRingPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WRAP_W = 5
) (
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [1:0]        updMode,
  input  logic [ADDR_W-1:0] stepBytes,
  input  logic [WRAP_W-1:0] wrapBits,
  output logic [ADDR_W-1:0] addrOut,
  output logic              wrapHit
);
  logic [ADDR_W-1:0] rawNext;
  logic [ADDR_W-1:0] keepMask;
  logic              moving;

  always_comb begin
    moving = (updMode == UPD_INC) || (updMode == UPD_DEC);
    case (updMode)
      UPD_INC: rawNext = addrIn + stepBytes;
      UPD_DEC: rawNext = addrIn - stepBytes;
      default: rawNext = addrIn;
    endcase
    if (wrapBits == '0) keepMask = '0;
    else keepMask = ~((ADDR_W'(1) << wrapBits) - ADDR_W'(1));
    addrOut = (addrIn & keepMask) | (rawNext & ~keepMask);
    wrapHit = moving && (wrapBits != '0) && ((rawNext & keepMask) != (addrIn & keepMask));
  end
endmodule

// File: rtl/dmaChanCtrl.sv
module dmaChanCtrl
  import dmaRingPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chanEn,
  input  logic        edgeSel,
  input  logic        reqN,
  input  logic        memAck,
  output logic        memReq,
  output logic        memWe,
  output logic        reqAck,
  output ctrlStrobe_t strobe
);
  chanState_e state, stateNext;
  logic reqPrev;
  logic pendQ;
  logic fallDet;
  logic goNow;

  always_comb begin
    fallDet = chanEn && edgeSel && reqPrev && !reqN;
    goNow   = (state == ST_IDLE) && chanEn && (edgeSel ? pendQ : !reqN);
    memReq  = (state != ST_IDLE);
    memWe   = (state == ST_WRITE);
    reqAck  = (state == ST_READ);
    strobe.startUnit  = goNow;
    strobe.latchRead  = (state == ST_READ) && memAck;
    strobe.finishUnit = (state == ST_WRITE) && memAck;
    stateNext = state;
    case (state)
      ST_IDLE:  if (goNow) stateNext = ST_READ;
      ST_READ:  if (memAck) stateNext = ST_WRITE;
      ST_WRITE: if (memAck) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reqPrev <= 1'b1;
      pendQ   <= 1'b0;
    end else begin
      state   <= stateNext;
      // disabled channel remembers the line as high, so a low line at enable is an edge
      reqPrev <= chanEn ? reqN : 1'b1;
      if (!chanEn) pendQ <= 1'b0;
      else pendQ <= (pendQ && !goNow) || fallDet;
    end
  end

  assert_hold_until_ack_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));
  assert_write_after_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> $past(reqAck));
  assert_idle_when_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && !chanEn) |=> !memReq);
endmodule

// File: rtl/dmaChanDatapath.sv
module dmaChanDatapath
  import dmaRingPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32,
  parameter int REG_W   = 32,
  parameter int WRAP_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  ctrlStrobe_t       strobe,
  input  logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              chanEn,
  output logic              edgeSel,
  output logic              doneIrq,
  output logic              wrapIrq,
  output logic              xferDone
);
  localparam int NUM_PTR = 2;
  localparam int PAD_W   = REG_W - CB_USED;

  logic [ADDR_W-1:0]  addrQ    [NUM_PTR];
  logic [1:0]         updQ     [NUM_PTR];
  logic [WRAP_W-1:0]  wrapQ    [NUM_PTR];
  logic [ADDR_W-1:0]  nextAddr [NUM_PTR];
  logic [NUM_PTR-1:0] hitVec;
  logic [COUNT_W-1:0] byteCount;
  logic [DATA_W-1:0]  dataQ;
  logic [1:0]         unitSize;
  logic doneFlag, wrapFlag, doneIe, wrapIe;
  logic [ADDR_W-1:0]  stepBytes;
  logic [COUNT_W-1:0] cntStep;
  logic               lastUnit;

  always_comb begin
    case (unitSize)
      2'd0:    stepBytes = ADDR_W'(1);
      2'd1:    stepBytes = ADDR_W'(2);
      default: stepBytes = ADDR_W'(4);
    endcase
    cntStep  = COUNT_W'(stepBytes);
    lastUnit = (byteCount <= cntStep);
  end

  for (genvar g = 0; g < NUM_PTR; g++) begin : gPtr
    dmaAddrStep #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W)) stepI (
      .addrIn(addrQ[g]), .updMode(updQ[g]), .stepBytes(stepBytes),
      .wrapBits(wrapQ[g]), .addrOut(nextAddr[g]), .wrapHit(hitVec[g]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PTR; i++) begin
        addrQ[i] <= '0;
        updQ[i]  <= UPD_FIXED;
        wrapQ[i] <= '0;
      end
      byteCount <= '0;
      dataQ     <= '0;
      unitSize  <= '0;
      chanEn    <= 1'b0;
      edgeSel   <= 1'b0;
      doneFlag  <= 1'b0;
      wrapFlag  <= 1'b0;
      doneIe    <= 1'b0;
      wrapIe    <= 1'b0;
    end else begin
      if (strobe.latchRead) dataQ <= memRdata;
      if (strobe.finishUnit) begin
        for (int i = 0; i < NUM_PTR; i++) addrQ[i] <= nextAddr[i];
        byteCount <= lastUnit ? '0 : byteCount - cntStep;
      end
      if (regWrEn) begin
        case (regAddr)
          REG_SRC: addrQ[0] <= regWrData[ADDR_W-1:0];
          REG_DST: addrQ[1] <= regWrData[ADDR_W-1:0];
          REG_CNT: byteCount <= regWrData[COUNT_W-1:0];
          default: begin
            chanEn   <= regWrData[CB_EN];
            doneFlag <= doneFlag & regWrData[CB_DONE];
            wrapFlag <= wrapFlag & regWrData[CB_WRAP];
            edgeSel  <= regWrData[CB_EDGE];
            unitSize <= regWrData[CB_SIZE +: 2];
            updQ[0]  <= regWrData[CB_SUPD +: 2];
            updQ[1]  <= regWrData[CB_DUPD +: 2];
            wrapQ[0] <= regWrData[CB_SWRAP +: WRAP_W];
            wrapQ[1] <= regWrData[CB_DWRAP +: WRAP_W];
            doneIe   <= regWrData[CB_DIE];
            wrapIe   <= regWrData[CB_WIE];
          end
        endcase
      end
      // hardware events take priority over a software write in the same cycle
      if (strobe.finishUnit) begin
        if (lastUnit) begin
          doneFlag <= 1'b1;
          chanEn   <= 1'b0;
        end
        if (|hitVec) wrapFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    case (regAddr)
      REG_SRC: regRdData = REG_W'(addrQ[0]);
      REG_DST: regRdData = REG_W'(addrQ[1]);
      REG_CNT: regRdData = REG_W'(byteCount);
      default: regRdData = {{PAD_W{1'b0}}, wrapIe, doneIe, wrapQ[1], wrapQ[0], updQ[1], updQ[0],
                            unitSize, edgeSel, wrapFlag, doneFlag, chanEn};
    endcase
    memAddr  = memWe ? addrQ[1] : addrQ[0];
    memSize  = unitSize;
    memWdata = dataQ;
    doneIrq  = doneFlag && doneIe;
    wrapIrq  = wrapFlag && wrapIe;
    xferDone = doneFlag;
  end

  assert_start_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startUnit |-> chanEn);
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finishUnit && !lastUnit && !regWrEn) |=> (byteCount == $past(byteCount) - $past(cntStep)));
  assert_end_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finishUnit && lastUnit && !regWrEn) |=> (doneFlag && !chanEn && byteCount == '0));
  assert_wrap_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finishUnit && !regWrEn && wrapQ[0] != '0) |=> (((addrQ[0] ^ $past(addrQ[0])) >> $past(wrapQ[0])) == '0));
  assert_wrap_flag_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finishUnit && (|hitVec)) |=> wrapFlag);
endmodule

// File: rtl/dmaRingChannel.sv
module dmaRingChannel
  import dmaRingPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32,
  parameter int REG_W   = 32,
  parameter int WRAP_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              reqN,
  output logic              reqAck,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic              doneIrq,
  output logic              wrapIrq,
  output logic              xferDone
);
  ctrlStrobe_t strobe;
  logic chanEn, edgeSel;

  dmaChanCtrl ctrlI (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .edgeSel(edgeSel), .reqN(reqN),
    .memAck(memAck), .memReq(memReq), .memWe(memWe), .reqAck(reqAck), .strobe(strobe));

  dmaChanDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W),
                    .REG_W(REG_W), .WRAP_W(WRAP_W)) dpI (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .strobe(strobe), .memWe(memWe), .memAddr(memAddr),
    .memSize(memSize), .memWdata(memWdata), .memRdata(memRdata), .chanEn(chanEn),
    .edgeSel(edgeSel), .doneIrq(doneIrq), .wrapIrq(wrapIrq), .xferDone(xferDone));
endmodule

// File: tb/dmaRingChannel_tb.sv
module dmaRingChannel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N = 512;
  localparam int WATCHDOG = 150000;

  typedef struct packed {
    logic [15:0] src; logic [15:0] dst; logic [15:0] cnt;
    logic [1:0] size; logic [1:0] sm; logic [1:0] dm;
    logic [4:0] sw; logic [4:0] dw; logic edgeMode;
    logic [15:0] expSrc; logic [15:0] expDst; logic expWrap;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{16'h040, 16'h080, 16'd16,  2'd0, 2'd1, 2'd1, 5'd3, 5'd0, 1'b1, 16'h040, 16'h090, 1'b1},
    '{16'h010, 16'h0A0, 16'd12,  2'd1, 2'd1, 2'd1, 5'd0, 5'd0, 1'b0, 16'h01C, 16'h0AC, 1'b0},
    '{16'h03C, 16'h0C0, 16'd8,   2'd2, 2'd2, 2'd1, 5'd0, 5'd0, 1'b0, 16'h034, 16'h0C8, 1'b0},
    '{16'h020, 16'h0EF, 16'd6,   2'd0, 2'd0, 2'd2, 5'd0, 5'd2, 1'b1, 16'h020, 16'h0ED, 1'b1},
    '{16'h000, 16'h100, 16'd256, 2'd0, 2'd1, 2'd1, 5'd3, 5'd0, 1'b1, 16'h000, 16'h200, 1'b1},
    '{16'h0F8, 16'h060, 16'd10,  2'd1, 2'd1, 2'd1, 5'd3, 5'd0, 1'b0, 16'h0FA, 16'h06A, 1'b1},
    '{16'h0FE, 16'h140, 16'd4,   2'd0, 2'd1, 2'd1, 5'd0, 5'd0, 1'b0, 16'h102, 16'h144, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic reqN = 1'b1;
  logic reqAck, memReq, memWe, memAck, doneIrq, wrapIrq, xferDone;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [1:0] memSize;

  logic [7:0] mem [MEM_N];
  logic [7:0] refMem [MEM_N];
  int checks = 0;
  int fails = 0;
  int writeCount = 0;
  int ackBad = 0;
  int ackSeen = 0;
  int cycle = 0;

  dmaRingChannel dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .reqN(reqN), .reqAck(reqAck), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck), .doneIrq(doneIrq), .wrapIrq(wrapIrq), .xferDone(xferDone));

  always #(CLK_PERIOD/2) clk = ~clk;

  assign memAck = memReq;

  function automatic int nBytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  always_comb begin
    memRdata = '0;
    for (int k = 0; k < 4; k++)
      if (k < nBytes(memSize)) memRdata[8*k +: 8] = mem[(int'(memAddr[8:0]) + k) % MEM_N];
  end

  always @(posedge clk) begin
    if (memReq && memWe) begin
      for (int k = 0; k < nBytes(memSize); k++)
        mem[(int'(memAddr[8:0]) + k) % MEM_N] <= memWdata[8*k +: 8];
      writeCount <= writeCount + 1;
    end
  end

  // R11 monitor: acknowledge exactly in the read phase
  always @(negedge clk) begin
    if (rstN) begin
      if (reqAck !== (memReq && !memWe)) ackBad++;
      if (reqAck) ackSeen++;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycle++;
      if (cycle > WATCHDOG) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual cycles %0d expected below %0d", cycle, WATCHDOG);
        summary();
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [31:0] ctrlWord(bit en, bit edgeMode, int size, int sm, int dm,
                                           int sw, int dw, bit dIe, bit wIe, bit keep);
    logic [31:0] w = '0;
    w[0] = en; w[1] = keep; w[2] = keep; w[3] = edgeMode;
    w[5:4] = 2'(size); w[7:6] = 2'(sm); w[9:8] = 2'(dm);
    w[14:10] = 5'(sw); w[19:15] = 5'(dw); w[20] = dIe; w[21] = wIe;
    return w;
  endfunction

  function automatic int refAdvance(input int a, input int mode, input int step, input int w,
                                    inout bit hit);
    int win, base, off;
    if (mode != 1 && mode != 2) return a;
    if (w == 0) return (mode == 1) ? a + step : a - step;
    win = 1 << w;
    base = a - (a % win);
    off = a - base;
    if (mode == 1) begin
      if (off + step >= win) hit = 1'b1;
      off = (off + step) % win;
    end else begin
      if (off < step) hit = 1'b1;
      off = (off + win - step) % win;
    end
    return base + off;
  endfunction

  task automatic refRun(input vec_t v);
    int s = v.src, d = v.dst, c = v.cnt, st = nBytes(v.size);
    bit hit = 1'b0;
    logic [7:0] buf8 [4];
    while (c > 0) begin
      for (int k = 0; k < st; k++) buf8[k] = refMem[(s + k) % MEM_N];
      for (int k = 0; k < st; k++) refMem[(d + k) % MEM_N] = buf8[k];
      s = refAdvance(s, v.sm, st, v.sw, hit);
      d = refAdvance(d, v.dm, st, v.dw, hit);
      c = (c <= st) ? 0 : c - st;
    end
  endtask

  task automatic fillMem();
    @(negedge clk);
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
      refMem[i] = mem[i];
    end
  endtask

  task automatic pulseReq();
    @(negedge clk); reqN = 1'b0;
    @(negedge clk); reqN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    int wc0, mism;
    repeat (3) @(negedge clk);
    // R12: reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), rd);
      check(rd == 0, "R12", "register after reset", rd, 0);
    end
    check(!memReq && !reqAck && !doneIrq && !wrapIrq && !xferDone, "R12", "outputs during reset",
          {memReq, reqAck, doneIrq, wrapIrq, xferDone}, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table-driven runs: R1 R2 R3 R6 R7 R8 R9
    for (int vi = 0; vi < NVEC; vi++) begin
      vec_t v = VECS[vi];
      int units = v.cnt / nBytes(v.size);
      fillMem();
      refRun(v);
      regWrite(2'd0, 32'(v.src));
      regWrite(2'd1, 32'(v.dst));
      regWrite(2'd2, 32'(v.cnt));
      regWrite(2'd3, ctrlWord(1'b1, v.edgeMode, v.size, v.sm, v.dm, v.sw, v.dw, 1'b0, 1'b0, 1'b0));
      if (v.edgeMode) begin
        for (int p = 0; p < units; p++) pulseReq();
      end else begin
        @(negedge clk) reqN = 1'b0;
        for (int t = 0; t < 4000 && !xferDone; t++) @(negedge clk);
        reqN = 1'b1;
      end
      repeat (4) @(negedge clk);
      mism = 0;
      for (int i = 0; i < MEM_N; i++) if (mem[i] !== refMem[i]) mism++;
      check(mism == 0, "R1", $sformatf("vector %0d memory image mismatches", vi), mism, 0);
      regRead(2'd0, rd);
      check(rd == 32'(v.expSrc), "R6/R7", $sformatf("vector %0d final source", vi), rd, 32'(v.expSrc));
      regRead(2'd1, rd);
      check(rd == 32'(v.expDst), "R6/R7", $sformatf("vector %0d final destination", vi), rd, 32'(v.expDst));
      regRead(2'd2, rd);
      check(rd == 0, "R9", $sformatf("vector %0d count", vi), rd, 0);
      regRead(2'd3, rd);
      check(rd[1:0] == 2'b10, "R9", $sformatf("vector %0d done set, enable clear", vi), rd[1:0], 2'b10);
      check(rd[2] == v.expWrap, "R8", $sformatf("vector %0d wrap flag", vi), rd[2], v.expWrap);
      regWrite(2'd3, 32'h0);
    end

    // R5: requests ignored while disabled
    regWrite(2'd0, 32'h055);
    regWrite(2'd2, 32'd4);
    regWrite(2'd3, ctrlWord(1'b0, 1'b1, 0, 1, 1, 0, 0, 1'b0, 1'b0, 1'b0));
    wc0 = writeCount;
    pulseReq(); pulseReq();
    @(negedge clk) reqN = 1'b0;
    repeat (6) @(negedge clk);
    check(writeCount == wc0, "R5", "writes while disabled", writeCount - wc0, 0);
    regRead(2'd0, rd);
    check(rd == 32'h055, "R5", "source while disabled", rd, 32'h055);
    // R3: line already low at enable gives exactly one transfer
    regWrite(2'd3, ctrlWord(1'b1, 1'b1, 0, 1, 1, 0, 0, 1'b0, 1'b0, 1'b0));
    repeat (12) @(negedge clk);
    check(writeCount == wc0 + 1, "R3", "transfers from low line at enable", writeCount - wc0, 1);
    regRead(2'd2, rd);
    check(rd == 3, "R3", "count after one unit", rd, 3);
    reqN = 1'b1;
    repeat (3) @(negedge clk);
    // R4: second edge during a transfer is held pending
    regWrite(2'd2, 32'd8);
    wc0 = writeCount;
    @(negedge clk) reqN = 1'b0;
    @(negedge clk) reqN = 1'b1;
    @(negedge clk) reqN = 1'b0;
    @(negedge clk) reqN = 1'b1;
    repeat (10) @(negedge clk);
    check(writeCount == wc0 + 2, "R4", "transfers from two close edges", writeCount - wc0, 2);
    regRead(2'd2, rd);
    check(rd == 6, "R4", "count after two units", rd, 6);
    regWrite(2'd3, 32'h0);

    // R10: flags, write-0 clear and interrupt gating
    regWrite(2'd0, 32'h1A0);
    regWrite(2'd1, 32'h1B0);
    regWrite(2'd2, 32'd2);
    regWrite(2'd3, ctrlWord(1'b1, 1'b0, 0, 1, 1, 1, 0, 1'b1, 1'b1, 1'b0));
    @(negedge clk) reqN = 1'b0;
    repeat (10) @(negedge clk);
    reqN = 1'b1;
    check(doneIrq && xferDone, "R10", "done interrupt raised", {doneIrq, xferDone}, 2'b11);
    check(wrapIrq, "R8", "wrap interrupt raised", wrapIrq, 1);
    regWrite(2'd3, ctrlWord(1'b0, 1'b0, 0, 1, 1, 1, 0, 1'b0, 1'b1, 1'b1));
    check(!doneIrq && xferDone, "R10", "interrupt gated by enable bit, flag kept", {doneIrq, xferDone}, 2'b01);
    regWrite(2'd3, ctrlWord(1'b0, 1'b0, 0, 1, 1, 1, 0, 1'b1, 1'b1, 1'b0));
    regRead(2'd3, rd);
    check(rd[2:1] == 2'b00, "R10", "flags cleared by writing 0", rd[2:1], 0);
    check(!doneIrq && !wrapIrq, "R10", "interrupts low after clear", {doneIrq, wrapIrq}, 0);

    // R11 and R2 monitor results
    check(ackBad == 0, "R11", "acknowledge outside read phase", ackBad, 0);
    check(ackSeen > 0, "R11", "acknowledge observed", ackSeen, 1);
    summary();
  end
endmodule